// File: doc/BRIEF.md
# DMA Cycle-Steal Bus Mode Sequencer

This block is the control sequencer of one DMA channel. It decides when the channel asks for the system bus, how long it keeps the bus, and when it gives the bus back. The choice depends on the selected bus mode. Software-side logic loads a unit count, a source start address and a destination start address with a one-cycle `arm` pulse. The channel then moves that many transfer units. Each unit is one read phase at the source followed by one write phase at the destination. Both phases run on a valid/ready memory handshake. Each address steps up by the unit size after every unit.

The channel has two bus modes. In cycle-steal mode it gives the bus back after every unit. The normal variant asks again at once if the active-low request line is still low. The intermittent variants first wait a fixed gap of 16 or 64 clocks after each release. In burst mode it keeps the bus from unit to unit. It releases the bus when the last unit ends, or at the end of a unit during which the request line went high. A `done` flag reports that the count has run out.

On the memory side, the channel raises `mem_valid` with an address, a direction and a size. It holds all of them stable until the memory raises `mem_ready`. A phase completes in the cycle where both are high. The memory may stall a phase for any number of cycles, and the channel keeps the bus during such a stall. The write phase carries the data taken from the read phase.

Top module: `dma_steal_seq`

## Requirements
- R1: While reset is low, and right after it, `bus_req`, `mem_valid` and `done` are 0 and `remaining` is 0.
- R2: An `arm` pulse while idle loads `xfer_count` and both start addresses and clears `done`. A count of 0 sets `done` on the next clock and never raises `bus_req`. An `arm` pulse while a transfer is in progress is ignored, and `remaining` keeps its value.
- R3: `bus_req` rises only while `dreq_n` is low, or while a request caught during a gap is pending. It then stays high until `bus_gnt` is seen. The first read phase raises `mem_valid` in the cycle after `bus_gnt` first reads high.
- R4: A phase holds `mem_valid`, `mem_write` and `mem_addr` stable until `mem_ready`. Each unit is one read phase (`mem_write`=0) followed by one write phase (`mem_write`=1). The write data equals the data captured by that unit's read phase.
- R5: In cycle-steal normal mode (`bus_mode`=0, `steal_sel`=0), `bus_req` drops in the cycle of each unit's write handshake. With `dreq_n` still low it rises again in the next cycle, so `bus_req` is low for exactly one cycle per unit.
- R6: In intermittent mode (`bus_mode`=0), `steal_sel`=1 selects a 16-clock gap and `steal_sel`=2 or 3 selects a 64-clock gap. With `dreq_n` low, `bus_req` rises again exactly gap+1 cycles after the cycle it dropped in.
- R7: During an intermittent gap, a low sample on `dreq_n` is remembered. The bus is requested when the gap ends even if `dreq_n` has gone high again. With no low sample, `bus_req` stays low after the gap.
- R8: In burst mode (`bus_mode`=1), the bus is kept between units while `dreq_n` stays low. It is released at the write handshake of the last unit, or of a unit that completes with `dreq_n` high. It is requested again when `dreq_n` goes low.
- R9: `remaining` drops by one at each write handshake. The write handshake that brings it to 0 releases the bus and sets `done` on the next clock. After that, `bus_req` stays low until the next `arm`.
- R10: The unit size code `unit_sel` gives 1<<`unit_sel` bytes for codes 0 to 5, and codes 6 and 7 act as 32 bytes. `mem_size` shows the clamped code. Read addresses start at `src_start`, write addresses start at `dst_start`, and both step by the unit size after each unit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | One-cycle pulse that loads the job when idle |
| xfer_count | input | CW | Number of units to move |
| src_start | input | AW | First read address |
| dst_start | input | AW | First write address |
| bus_mode | input | 1 | 0 cycle-steal, 1 burst |
| steal_sel | input | 2 | 0 normal, 1 gap of 16, 2 or 3 gap of 64 |
| unit_sel | input | 3 | Unit size code (bytes = 1<<code, capped at 32) |
| dreq_n | input | 1 | Active-low level transfer request |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| mem_valid | output | 1 | Phase valid |
| mem_ready | input | 1 | Phase accepted by memory |
| mem_write | output | 1 | 0 read phase, 1 write phase |
| mem_addr | output | AW | Phase address |
| mem_size | output | 3 | Clamped unit size code |
| mem_rdata | input | DW | Read data, sampled at the read handshake |
| mem_wdata | output | DW | Write data for the write phase |
| remaining | output | CW | Units left to move |
| done | output | 1 | Job finished |

## Verification
The assertions take for granted that the arbiter keeps `bus_grant` high for as long as `bus_req` stays high. They also assume that `bus_mode`, `steal_sel` and `unit_sel` do not change while a job runs, since the gap-window check reads the live gap selection. The bench keeps within both. Its arbiter model grants after a programmable delay and drops the grant one clock after the request falls. The configuration inputs change only while the channel is idle, just before an `arm` pulse. The memory model stalls each phase by a programmable latency and never raises `mem_ready` without `mem_valid`.

// File: rtl/dss_pkg.sv
package dss_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT,
    S_GAP,
    S_REQ,
    S_RD,
    S_WR
  } seq_state_e;

  localparam logic [2:0] SIZE_CODE_MAX = 3'd5;

  function automatic logic [2:0] clamp_size(input logic [2:0] code);
    return (code > SIZE_CODE_MAX) ? SIZE_CODE_MAX : code;
  endfunction
endpackage

// File: rtl/dss_gap_timer.sv
module dss_gap_timer #(
  parameter int unsigned GAP_SHORT = 16,
  parameter int unsigned GAP_LONG  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic long_sel,
  output logic running,
  output logic expire
);
  localparam int unsigned CNT_W = $clog2(GAP_LONG) + 1;
  localparam logic [CNT_W-1:0] LOAD_SHORT = CNT_W'(GAP_SHORT - 1);
  localparam logic [CNT_W-1:0] LOAD_LONG  = CNT_W'(GAP_LONG - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start) begin
      run_q <= 1'b1;
      cnt_q <= long_sel ? LOAD_LONG : LOAD_SHORT;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign running = run_q;
  assign expire  = run_q && (cnt_q == '0);

  // R6: a running gap always counts down toward expiry
  assert_gap_countdown_R6: assert property (@(posedge clk) disable iff (!rst_n)
    running && !expire && !start |=> running && (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/dss_unit_ctr.sv
module dss_unit_ctr import dss_pkg::*; #(
  parameter int unsigned CW = 16,
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] cnt_in,
  input  logic [AW-1:0] src_in,
  input  logic [AW-1:0] dst_in,
  input  logic [2:0]    size_code,
  input  logic          unit_done,
  output logic [CW-1:0] remaining,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic          last_unit
);
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] src_q, dst_q;
  logic [AW-1:0] step;

  assign step = AW'(1) << clamp_size(size_code);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      src_q <= '0;
      dst_q <= '0;
    end else if (load) begin
      cnt_q <= cnt_in;
      src_q <= src_in;
      dst_q <= dst_in;
    end else if (unit_done) begin
      cnt_q <= cnt_q - 1'b1;
      src_q <= src_q + step;
      dst_q <= dst_q + step;
    end
  end

  assign remaining = cnt_q;
  assign src_addr  = src_q;
  assign dst_addr  = dst_q;
  assign last_unit = (cnt_q == CW'(1));

  // R9: one decrement per completed unit, never below zero
  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    unit_done && !load |=> remaining == $past(remaining) - 1'b1);
  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    unit_done |-> remaining != '0);
  // R10: addresses move by the unit size
  assert_addr_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    unit_done && !load |=> (src_addr - $past(src_addr)) == (dst_addr - $past(dst_addr)));
endmodule

// File: rtl/dss_bus_fsm.sv
module dss_bus_fsm import dss_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic       count_zero,
  input  logic       dreq_n,
  input  logic       burst_mode,
  input  logic [1:0] steal_sel,
  input  logic       bus_gnt,
  input  logic       mem_ready,
  input  logic       last_unit,
  input  logic       gap_running,
  input  logic       gap_expire,
  output logic       bus_req,
  output logic       mem_valid,
  output logic       mem_write,
  output logic       load,
  output logic       unit_done,
  output logic       rd_done,
  output logic       gap_start,
  output logic       gap_long,
  output logic       done
);
  seq_state_e st_q, st_nx;
  logic pend_q, done_q;
  logic want, rd_hs, wr_hs, keep_bus, owns;

  assign want      = !dreq_n;
  assign rd_hs     = (st_q == S_RD) && mem_ready;
  assign wr_hs     = (st_q == S_WR) && mem_ready;
  assign keep_bus  = burst_mode && !last_unit && want;
  assign load      = (st_q == S_IDLE) && arm;
  assign unit_done = wr_hs;
  assign rd_done   = rd_hs;
  assign gap_long  = steal_sel[1];
  assign gap_start = wr_hs && !last_unit && !burst_mode && (steal_sel != 2'd0);
  assign owns      = (st_q == S_REQ) || (st_q == S_RD) || (st_q == S_WR);
  assign bus_req   = owns && !(wr_hs && !keep_bus);
  assign mem_valid = (st_q == S_RD) || (st_q == S_WR);
  assign mem_write = (st_q == S_WR);
  assign done      = done_q;

  always_comb begin
    st_nx = st_q;
    unique case (st_q)
      S_IDLE: if (arm && !count_zero) st_nx = S_WAIT;
      S_WAIT: if (want) st_nx = S_REQ;
      S_GAP:  if (gap_expire) st_nx = (pend_q || want) ? S_REQ : S_WAIT;
      S_REQ:  if (bus_gnt) st_nx = S_RD;
      S_RD:   if (mem_ready) st_nx = S_WR;
      S_WR: begin
        if (mem_ready) begin
          if (last_unit)                 st_nx = S_IDLE;
          else if (keep_bus)             st_nx = S_RD;
          else if (burst_mode)           st_nx = S_WAIT;
          else if (steal_sel == 2'd0)    st_nx = want ? S_REQ : S_WAIT;
          else                           st_nx = S_GAP;
        end
      end
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q <= st_nx;
      if (gap_start)          pend_q <= want;
      else if (st_q == S_GAP) pend_q <= pend_q | want;
      else                    pend_q <= 1'b0;
      if (load)                    done_q <= count_zero;
      else if (wr_hs && last_unit) done_q <= 1'b1;
    end
  end

  // R3: request held until granted; reads begin right after the grant
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req);
  assert_read_after_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) |-> $past(bus_gnt) && !mem_write);
  // R4: a stalled phase keeps its direction
  assert_valid_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_write));
  // R6: no request while the gap runs
  assert_gap_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gap_running |-> !bus_req);
  // R9: a finished job does not touch the bus
  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_req && !mem_valid);
endmodule

// File: rtl/dma_steal_seq.sv
module dma_steal_seq import dss_pkg::*; #(
  parameter int unsigned CW        = 16,
  parameter int unsigned AW        = 32,
  parameter int unsigned DW        = 256,
  parameter int unsigned GAP_SHORT = 16,
  parameter int unsigned GAP_LONG  = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic [CW-1:0] xfer_count,
  input  logic [AW-1:0] src_start,
  input  logic [AW-1:0] dst_start,
  input  logic          bus_mode,
  input  logic [1:0]    steal_sel,
  input  logic [2:0]    unit_sel,
  input  logic          dreq_n,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [2:0]    mem_size,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] mem_wdata,
  output logic [CW-1:0] remaining,
  output logic          done
);
  localparam int unsigned WIN_W = $clog2(GAP_LONG + 2) + 1;

  logic load, unit_done, rd_done, gap_start, gap_long, gap_running, gap_expire;
  logic last_unit;
  logic [AW-1:0] src_addr, dst_addr;
  logic [DW-1:0] buf_q;

  dss_unit_ctr #(.CW(CW), .AW(AW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(load), .cnt_in(xfer_count),
    .src_in(src_start), .dst_in(dst_start), .size_code(unit_sel),
    .unit_done(unit_done), .remaining(remaining), .src_addr(src_addr),
    .dst_addr(dst_addr), .last_unit(last_unit)
  );

  dss_gap_timer #(.GAP_SHORT(GAP_SHORT), .GAP_LONG(GAP_LONG)) u_gap (
    .clk(clk), .rst_n(rst_n), .start(gap_start), .long_sel(gap_long),
    .running(gap_running), .expire(gap_expire)
  );

  dss_bus_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .arm(arm), .count_zero(xfer_count == '0),
    .dreq_n(dreq_n), .burst_mode(bus_mode), .steal_sel(steal_sel),
    .bus_gnt(bus_gnt), .mem_ready(mem_ready), .last_unit(last_unit),
    .gap_running(gap_running), .gap_expire(gap_expire), .bus_req(bus_req),
    .mem_valid(mem_valid), .mem_write(mem_write), .load(load),
    .unit_done(unit_done), .rd_done(rd_done), .gap_start(gap_start),
    .gap_long(gap_long), .done(done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       buf_q <= '0;
    else if (rd_done) buf_q <= mem_rdata;
  end

  assign mem_addr  = mem_write ? dst_addr : src_addr;
  assign mem_size  = clamp_size(unit_sel);
  assign mem_wdata = buf_q;

  // Gap window checker: counts clocks since a gap was started
  logic             win_armed;
  logic [WIN_W-1:0] win_cnt;
  logic [WIN_W-1:0] gap_n;

  assign gap_n = steal_sel[1] ? WIN_W'(GAP_LONG) : WIN_W'(GAP_SHORT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_armed <= 1'b0;
      win_cnt   <= '0;
    end else if (gap_start) begin
      win_armed <= 1'b1;
      win_cnt   <= WIN_W'(1);
    end else if (win_armed && bus_req) begin
      win_armed <= 1'b0;
    end else if (win_armed && (win_cnt != '1)) begin
      win_cnt <= win_cnt + 1'b1;
    end
  end

  // R6: re-request only after the full gap
  assert_gap_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    win_armed && bus_req |-> win_cnt > gap_n);
  // R9: done only with an empty count
  assert_done_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> remaining == '0);
  // R4: a stalled phase keeps its address
  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> $stable(mem_addr));
endmodule

// File: tb/sim_dma_steal_seq.sv
`timescale 1ns/1ps
module sim_dma_steal_seq;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, arm, bus_mode, dreq_n, bus_req, bus_gnt;
  logic mem_valid, mem_ready, mem_write, done;
  logic [15:0] xfer_count, remaining;
  logic [31:0] src_start, dst_start, mem_addr;
  logic [1:0] steal_sel;
  logic [2:0] unit_sel, mem_size;
  logic [255:0] mem_rdata, mem_wdata;

  dma_steal_seq u0 (
    .clk(clk), .rst_n(rst_n), .arm(arm), .xfer_count(xfer_count),
    .src_start(src_start), .dst_start(dst_start), .bus_mode(bus_mode),
    .steal_sel(steal_sel), .unit_sel(unit_sel), .dreq_n(dreq_n),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
    .remaining(remaining), .done(done)
  );

  int checks = 0, fails = 0;
  int lat = 0, gdly = 0, gcnt = 0, wait_c = 0;

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Arbiter model: grant after gdly cycles, drop one clock after request falls
  always @(posedge clk) begin
    if (!rst_n || !bus_req) begin gcnt <= 0; bus_gnt <= 1'b0; end
    else if (gcnt >= gdly) bus_gnt <= 1'b1;
    else gcnt <= gcnt + 1;
  end

  // Memory model: ready after lat stall cycles
  always @(posedge clk) begin
    if (!rst_n || !mem_valid || mem_ready) wait_c <= 0;
    else wait_c <= wait_c + 1;
  end
  assign mem_ready = mem_valid && (wait_c >= lat);
  assign mem_rdata = {8{(mem_addr * 32'h9E3779B1) ^ 32'h00C0FFEE}};

  // Monitor state
  int cyc = 0, fall_cyc = 0, gnt_rise = 0, nrel = 0, units = 0, exp_gap = 0;
  logic have_fall = 1'b0, in_unit = 1'b0;
  logic req_q = 1'b0, gnt_q = 1'b0, val_q = 1'b0, rdy_q = 1'b0, wr_q = 1'b0;
  logic [31:0] addr_q = '0, exp_src = '0, exp_dst = '0, step = 32'd1;
  logic [2:0] exp_size = '0;
  logic [255:0] rd_seen = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (req_q && !bus_req) begin nrel++; fall_cyc = cyc; have_fall = 1'b1; end
      if (!req_q && bus_req && have_fall && exp_gap != 0)
        chk((cyc - fall_cyc) == exp_gap, (exp_gap == 1) ? "R5 release gap" : "R6 gap length",
            longint'(cyc - fall_cyc), longint'(exp_gap));
      if (bus_gnt && !gnt_q) gnt_rise = cyc;
      if (mem_valid && !val_q)
        chk(cyc == gnt_rise + 1, "R3 read after grant", longint'(cyc), longint'(gnt_rise + 1));
      if (val_q && !rdy_q)
        chk(mem_valid && mem_write == wr_q && mem_addr == addr_q, "R4 stall hold",
            longint'(mem_addr), longint'(addr_q));
      if (mem_valid && mem_ready) begin
        chk(mem_size == exp_size, "R10 size code", longint'(mem_size), longint'(exp_size));
        if (!mem_write) begin
          chk(!in_unit, "R4 read order", longint'(in_unit), 0);
          chk(mem_addr == exp_src, "R10 read addr", longint'(mem_addr), longint'(exp_src));
          rd_seen = mem_rdata;
          in_unit = 1'b1;
        end else begin
          chk(in_unit, "R4 write order", longint'(in_unit), 1);
          chk(mem_addr == exp_dst, "R10 write addr", longint'(mem_addr), longint'(exp_dst));
          chk(mem_wdata == rd_seen, "R4 write data", longint'(mem_wdata[63:0]), longint'(rd_seen[63:0]));
          in_unit = 1'b0;
          units++;
          exp_src = exp_src + step;
          exp_dst = exp_dst + step;
        end
      end
      req_q = bus_req; gnt_q = bus_gnt; val_q = mem_valid; rdy_q = mem_ready;
      wr_q = mem_write; addr_q = mem_addr;
    end
  end

  typedef struct packed {
    logic       mode;
    logic [1:0] ssel;
    logic [2:0] usel;
    logic [7:0] cnt;
    logic [3:0] lt;
    logic [3:0] gd;
    logic [7:0] rel;
    logic [7:0] gap;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 3'd0, 8'd4, 4'd0, 4'd0, 8'd4, 8'd1},
    '{1'b0, 2'd0, 3'd2, 8'd3, 4'd2, 4'd2, 8'd3, 8'd1},
    '{1'b0, 2'd1, 3'd3, 8'd3, 4'd1, 4'd0, 8'd3, 8'd17},
    '{1'b0, 2'd2, 3'd4, 8'd2, 4'd0, 4'd1, 8'd2, 8'd65},
    '{1'b0, 2'd3, 3'd5, 8'd2, 4'd0, 4'd0, 8'd2, 8'd65},
    '{1'b1, 2'd0, 3'd1, 8'd5, 4'd1, 4'd0, 8'd1, 8'd0},
    '{1'b1, 2'd0, 3'd7, 8'd3, 4'd0, 4'd3, 8'd1, 8'd0},
    '{1'b1, 2'd1, 3'd6, 8'd1, 4'd2, 4'd1, 8'd1, 8'd0},
    '{1'b0, 2'd0, 3'd1, 8'd1, 4'd0, 4'd0, 8'd1, 8'd1}
  };

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic start_job(input logic md, input logic [1:0] ss, input logic [2:0] us,
                           input int cnt, input int lt, input int gd, input int gap,
                           input logic [31:0] sa, input logic [31:0] da);
    bus_mode = md; steal_sel = ss; unit_sel = us; xfer_count = 16'(cnt);
    src_start = sa; dst_start = da; lat = lt; gdly = gd; exp_gap = gap;
    nrel = 0; units = 0; have_fall = 1'b0; in_unit = 1'b0;
    exp_src = sa; exp_dst = da;
    exp_size = (us > 3'd5) ? 3'd5 : us;
    step = 32'd1 << exp_size;
    arm = 1'b1;
    tick();
    arm = 1'b0;
  endtask

  task automatic wait_done(input int limit);
    for (int i = 0; i < limit && !done; i++) tick();
  endtask

  initial begin
    rst_n = 1'b0; arm = 1'b0; bus_mode = 1'b0; steal_sel = 2'd0; unit_sel = 3'd0;
    dreq_n = 1'b1; xfer_count = '0; src_start = '0; dst_start = '0;
    repeat (3) tick();
    chk(!bus_req && !mem_valid && !done, "R1 outputs in reset",
        longint'({bus_req, mem_valid, done}), 0);
    rst_n = 1'b1;
    tick();
    chk(!bus_req && !mem_valid && !done && remaining == 0, "R1 after reset",
        longint'({bus_req, mem_valid, done}), 0);
    chk(remaining == 0, "R1 remaining", longint'(remaining), 0);

    // Vector table walk
    for (int v = 0; v < NV; v++) begin
      dreq_n = 1'b0;
      start_job(VECS[v].mode, VECS[v].ssel, VECS[v].usel, int'(VECS[v].cnt),
                int'(VECS[v].lt), int'(VECS[v].gd), int'(VECS[v].gap),
                32'h1000_0000 + 32'(v) * 32'h400, 32'h2000_0000 + 32'(v) * 32'h400);
      wait_done(3000);
      tick();
      chk(done, "R9 done", longint'(done), 1);
      chk(units == int'(VECS[v].cnt), "R9 unit count", longint'(units), longint'(VECS[v].cnt));
      chk(remaining == 0, "R9 remaining zero", longint'(remaining), 0);
      chk(nrel == int'(VECS[v].rel), VECS[v].mode ? "R8 burst releases" : "R5 releases per unit",
          longint'(nrel), longint'(VECS[v].rel));
      chk(!bus_req, "R9 bus idle after done", longint'(bus_req), 0);
    end

    // R2: zero count finishes without touching the bus
    dreq_n = 1'b0;
    start_job(1'b0, 2'd0, 3'd0, 0, 0, 0, 0, 32'h3000_0000, 32'h3800_0000);
    chk(done && remaining == 0, "R2 zero count done", longint'(done), 1);
    repeat (5) tick();
    chk(!bus_req && nrel == 0 && units == 0, "R2 zero count no request", longint'(bus_req), 0);

    // R3: no request while dreq_n is high; R2: arm while busy ignored
    dreq_n = 1'b1;
    start_job(1'b0, 2'd0, 3'd2, 2, 1, 1, 1, 32'h4000_0000, 32'h4800_0000);
    repeat (10) tick();
    chk(!bus_req, "R3 no request without dreq", longint'(bus_req), 0);
    xfer_count = 16'd9; arm = 1'b1;
    tick();
    arm = 1'b0;
    tick();
    chk(remaining == 2, "R2 arm while busy ignored", longint'(remaining), 2);
    dreq_n = 1'b0;
    wait_done(500);
    tick();
    chk(done && units == 2, "R3 job completes once requested", longint'(units), 2);

    // R7: request caught during a gap is kept pending
    dreq_n = 1'b0;
    start_job(1'b0, 2'd1, 3'd0, 2, 3, 0, 17, 32'h5000_0000, 32'h5800_0000);
    for (int i = 0; i < 200 && !(mem_valid && mem_write); i++) tick();
    dreq_n = 1'b1;
    for (int i = 0; i < 200 && nrel < 1; i++) tick();
    repeat (3) tick();
    dreq_n = 1'b0;
    tick();
    dreq_n = 1'b1;
    wait_done(500);
    tick();
    chk(done && units == 2, "R7 pending request served", longint'(units), 2);

    // R7: no request caught during the gap leaves the bus alone
    dreq_n = 1'b0;
    start_job(1'b0, 2'd1, 3'd1, 2, 3, 0, 0, 32'h6000_0000, 32'h6800_0000);
    for (int i = 0; i < 200 && !(mem_valid && mem_write); i++) tick();
    dreq_n = 1'b1;
    for (int i = 0; i < 200 && nrel < 1; i++) tick();
    repeat (30) tick();
    chk(!bus_req, "R7 no pending request", longint'(bus_req), 0);
    chk(remaining == 1, "R7 remaining after gap", longint'(remaining), 1);
    dreq_n = 1'b0;
    wait_done(500);
    tick();
    chk(done && units == 2, "R7 job completes", longint'(units), 2);

    // R8: burst released when dreq_n goes high during a unit
    dreq_n = 1'b0;
    start_job(1'b1, 2'd0, 3'd2, 5, 2, 0, 0, 32'h7000_0000, 32'h7800_0000);
    for (int i = 0; i < 500 && !(units == 2 && mem_valid && !mem_write); i++) tick();
    dreq_n = 1'b1;
    repeat (12) tick();
    chk(!bus_req, "R8 burst released", longint'(bus_req), 0);
    chk(remaining == 2, "R8 remaining at release", longint'(remaining), 2);
    chk(nrel == 1, "R8 single release", longint'(nrel), 1);
    dreq_n = 1'b0;
    wait_done(500);
    tick();
    chk(done && units == 5, "R8 burst resumes", longint'(units), 5);
    chk(nrel == 2, "R8 releases after resume", longint'(nrel), 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule